// File: doc/BRIEF.md
# USB device transaction responder

This block sits between a low-speed USB packet receiver/transmitter pair and a small set of endpoint buffers. The receiver hands it the bytes of each packet and a strobe when the packet ends. The responder decodes the packet by its PID and checks the device address carried by token packets. It remembers the last SETUP or OUT token it saw. It then either stays silent or starts a reply on a byte-stream transmit port: a one-byte handshake, or a data packet read from an endpoint buffer.

Received data packets go into a single receive buffer. That buffer is marked busy until the host side releases it. While it is busy, further data and IN tokens are answered with NAK. Each of the two IN endpoints has a transmit field with two uses. It holds either a handshake PID, which is sent as it is, or a byte count. A byte count sends the buffered packet and resets the field to NAK at once. A newly assigned device address is held pending and becomes active only after a data packet has gone out, so the status stage of an address change still completes on the old address.

Buffer contents, transmit fields, the pending address and the buffer release are reached through a simple register port. Reads are combinational.

Top module: `usb_txn_responder`

## Requirements
- R1: After reset the transmit port is idle, the active address (read 0x22) is 0, both transmit fields (read 0x20 for endpoint 0, 0x21 for endpoint 1) hold NAK (0x5A), and the stored receive length (read 0x24) is 0.
- R2: A packet that ends after fewer than 3 bytes produces no reply and leaves the remembered token unchanged.
- R3: Byte 0 of every packet is the PID. In a token, byte 1 carries the address in bits 6:0 and the endpoint-select bit in bit 7. A token whose address differs from the active address clears the remembered token and gets no reply.
- R4: A SETUP (0x2D) or OUT (0xE1) token with a matching address is remembered and gets no reply. Any other PID with a matching address, other than IN and data, clears the remembered token. DATA0 (0xC3) or DATA1 (0x4B) with no remembered token gets no reply.
- R5: A data packet that arrives while the receive length is nonzero is answered with NAK (0x5A), and the stored bytes and length stay unchanged.
- R6: A data packet of fewer than 4 bytes is answered with ACK (0xD2) and is not stored. A longer one has the bytes that follow its PID stored at read addresses 0x00 upward. Its length minus one goes to 0x24, the remembered token PID goes to 0x25, and the packet is answered with ACK.
- R7: An IN token (0x69) that arrives while the receive length is nonzero is answered with NAK, and the transmit field is left unchanged.
- R8: When a transmit field (write 0x20/0x21) has bit 4 set, an IN reply is that one byte, flagged last, and the field is kept. When bit 4 is clear, the reply is the first n bytes of that endpoint's buffer (write 0x00+i for endpoint 0, 0x10+i for endpoint 1), with n from 1 to TX_DEPTH. The final byte is flagged last, and the field reads NAK from the first reply byte on.
- R9: The first byte of any reply is presented on tx_valid in the clock cycle right after rx_end.
- R10: A pending address written to 0x22 becomes the active address when the last byte of a data reply is accepted. A handshake reply never changes the active address.
- R11: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values.
- R12: A packet longer than RX_DEPTH+1 bytes is ignored entirely: no reply and no store.
- R13: Any write to 0x23 releases the receive buffer, and the receive length then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of the current packet (after its last byte) |
| tx_valid | output | 1 | A reply byte is presented |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Presented byte is the last of the reply |
| tx_ready | input | 1 | Transmitter accepts the presented byte |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 6 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational) |

## Verification
The responder is driven with complete transactions: IN tokens to each endpoint, with the field holding a handshake, a byte count, or NAK. It also sees SETUP/OUT tokens followed by data packets of zero-payload, short, full and oversize length. Each pattern is repeated with the receive buffer free and busy, so that ACK and NAK paths and storing and not storing can be told apart. Address changes are sent once through a handshake reply and once through a data reply, to separate the two commit cases. Wrong-address, unknown-PID and too-short packets come before a data packet, so that a cleared or kept token shows up as reply or silence. One data reply is drained against a toggling ready to expose holding faults.

// File: rtl/usb_txn_responder.sv
module usb_txn_responder #(
  parameter int TX_DEPTH = 11,
  parameter int RX_DEPTH = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_end,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       tx_ready,
  input  logic       host_we,
  input  logic [5:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam int CNT_W = $clog2(RX_DEPTH + 3);
  localparam int RXA_W = $clog2(RX_DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RX_DEPTH);

  logic [7:0] ep_buf [2][TX_DEPTH];
  logic [7:0] rx_mem [RX_DEPTH];
  logic [7:0] ep_field [2];
  logic [CNT_W-1:0] rx_cnt;
  logic [7:0] pid_q, tok_q, cur_tok, rx_tok, rx_len, tx_hs;
  logic [6:0] act_addr, pend_addr;
  logic       tx_active, tx_isdata, tx_ep;
  logic [3:0] tx_idx, tx_len;

  wire [CNT_W-1:0] wr_pos = rx_cnt - 1'b1;
  wire is_data  = (pid_q == PID_DATA0) || (pid_q == PID_DATA1);
  wire addr_ok  = tok_q[6:0] == act_addr;
  wire rx_busy  = rx_len != 8'd0;
  wire pkt_ok   = rx_end && !tx_active && rx_cnt >= CNT_W'(3) && rx_cnt <= CNT_LIM;
  wire [7:0] in_field = ep_field[tok_q[7]];
  wire tx_fire  = tx_active && tx_ready;

  assign tx_valid = tx_active;
  assign tx_data  = tx_isdata ? ep_buf[tx_ep][tx_idx] : tx_hs;
  assign tx_last  = tx_isdata ? (tx_idx == tx_len - 4'd1) : 1'b1;

  always_ff @(posedge clk)
    if (host_we && !host_addr[5] && host_addr[3:0] < 4'(TX_DEPTH))
      ep_buf[host_addr[4]][host_addr[3:0]] <= host_wdata;

  always_ff @(posedge clk)
    if (rx_valid && !rx_busy && rx_cnt != '0 && rx_cnt <= CNT_LAST)
      rx_mem[wr_pos[RXA_W-1:0]] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt      <= '0;
      pid_q       <= '0;
      tok_q       <= '0;
      cur_tok     <= '0;
      rx_tok      <= '0;
      rx_len      <= '0;
      tx_hs       <= '0;
      act_addr    <= '0;
      pend_addr   <= '0;
      ep_field[0] <= PID_NAK;
      ep_field[1] <= PID_NAK;
      tx_active   <= 1'b0;
      tx_isdata   <= 1'b0;
      tx_ep       <= 1'b0;
      tx_idx      <= '0;
      tx_len      <= '0;
    end else begin
      if (rx_valid) begin
        if (rx_cnt == '0) pid_q <= rx_data;
        if (rx_cnt == CNT_W'(1)) tok_q <= rx_data;
        if (rx_cnt != CNT_MAX) rx_cnt <= rx_cnt + 1'b1;
      end
      if (rx_end) rx_cnt <= '0;

      if (host_we && host_addr[5]) begin
        case (host_addr[1:0])
          2'd0: ep_field[0] <= host_wdata;
          2'd1: ep_field[1] <= host_wdata;
          2'd2: pend_addr   <= host_wdata[6:0];
          default: rx_len   <= '0;
        endcase
      end

      if (pkt_ok) begin
        if (is_data) begin
          if (cur_tok != '0) begin
            tx_active <= 1'b1;
            tx_isdata <= 1'b0;
            tx_idx    <= '0;
            if (rx_busy) tx_hs <= PID_NAK;
            else begin
              tx_hs <= PID_ACK;
              if (rx_cnt >= CNT_W'(4)) begin
                rx_len <= 8'(wr_pos);
                rx_tok <= cur_tok;
              end
            end
          end
        end else if (!addr_ok) begin
          cur_tok <= '0;
        end else if (pid_q == PID_IN) begin
          tx_active <= 1'b1;
          tx_idx    <= '0;
          tx_ep     <= tok_q[7];
          if (rx_busy) begin
            tx_isdata <= 1'b0;
            tx_hs     <= PID_NAK;
          end else if (in_field[4]) begin
            tx_isdata <= 1'b0;
            tx_hs     <= in_field;
          end else begin
            tx_isdata <= 1'b1;
            tx_len    <= in_field[3:0];
            ep_field[tok_q[7]] <= PID_NAK;
          end
        end else if (pid_q == PID_SETUP || pid_q == PID_OUT) begin
          cur_tok <= pid_q;
        end else begin
          cur_tok <= '0;
        end
      end

      if (tx_fire) begin
        if (tx_last) begin
          tx_active <= 1'b0;
          if (tx_isdata) act_addr <= pend_addr;
        end else begin
          tx_idx <= tx_idx + 4'd1;
        end
      end
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (!host_addr[5]) begin
      if (!host_addr[4] && host_addr[3:0] < 4'(RX_DEPTH))
        host_rdata = rx_mem[host_addr[RXA_W-1:0]];
    end else begin
      case (host_addr[2:0])
        3'd0: host_rdata = ep_field[0];
        3'd1: host_rdata = ep_field[1];
        3'd2: host_rdata = {1'b0, act_addr};
        3'd4: host_rdata = rx_len;
        3'd5: host_rdata = rx_tok;
        default: host_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/usb_txn_responder_chk.sv
module usb_txn_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_end,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_isdata,
  input logic       tx_ep,
  input logic [6:0] act_addr,
  input logic [7:0] rx_len,
  input logic [7:0] field0,
  input logic [7:0] field1
);
  AST_RESP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(rx_end)); // R9
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R11
  AST_HANDSHAKE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_isdata |-> tx_last); // R8
  AST_FIELD_NAK_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) && tx_isdata |-> (tx_ep ? field1 : field0) == 8'h5A); // R8
  AST_ADDR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    act_addr != $past(act_addr) |-> $past(tx_valid && tx_ready && tx_last && tx_isdata)); // R10
  AST_STORED_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len != 8'd0 |-> rx_len >= 8'd3); // R6
endmodule

bind usb_txn_responder usb_txn_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_end(rx_end), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .tx_isdata(tx_isdata), .tx_ep(tx_ep), .act_addr(act_addr),
  .rx_len(rx_len), .field0(ep_field[0]), .field1(ep_field[1])
);

// File: tb/usb_txn_responder_test.sv
module usb_txn_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int RXD = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_end = 1'b0, tx_ready = 1'b1, host_we = 1'b0;
  logic [7:0] rx_data = '0, host_wdata = '0;
  logic [5:0] host_addr = '0;
  logic tx_valid, tx_last;
  logic [7:0] tx_data, host_rdata;

  int checks = 0, errors = 0;
  bit stall = 1'b0;
  string cur_req = "R1";
  logic [8:0] exp_q[$];
  logic [7:0] pkt [0:15];

  usb_txn_responder #(.TX_DEPTH(11), .RX_DEPTH(RXD)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_end(rx_end), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1 tx_ready = stall ? ~tx_ready : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(cur_req, {tx_last, tx_data}, 9'h1FF);
      else chk(cur_req, {tx_last, tx_data}, exp_q.pop_front());
    end
  end

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1 host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [5:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1 host_addr = a;
    @(negedge clk); chk(req, host_rdata, exp);
  endtask

  task automatic push_hs(input logic [7:0] b);
    exp_q.push_back({1'b1, b});
  endtask

  task automatic send_pkt(input int n, input bit resp, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 rx_valid = 1'b1; rx_data = pkt[i];
    end
    @(posedge clk); #1 rx_valid = 1'b0; rx_end = 1'b1;
    @(posedge clk); #1 rx_end = 1'b0;
    @(negedge clk); chk({req, " R9 timing"}, tx_valid, resp);
    for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
    @(negedge clk);
    chk({req, " drained"}, {exp_q.size() != 0, tx_valid}, 0);
    exp_q.delete();
  endtask

  task automatic token(input logic [7:0] pid, input logic [6:0] a, input logic ep,
                       input bit resp, input string req);
    pkt[0] = pid; pkt[1] = {ep, a}; pkt[2] = 8'h00;
    send_pkt(3, resp, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); chk("R1 idle", tx_valid, 0);
    host_rd(6'h22, 8'h00, "R1 addr");
    host_rd(6'h20, 8'h5A, "R1 field0");
    host_rd(6'h21, 8'h5A, "R1 field1");
    host_rd(6'h24, 8'h00, "R1 rxlen");

    push_hs(8'h5A); token(8'h69, 7'd0, 1'b0, 1'b1, "R8 default NAK");

    host_wr(6'h00, 8'h4B); host_wr(6'h01, 8'hA1);
    host_wr(6'h02, 8'hB2); host_wr(6'h03, 8'hC3);
    host_wr(6'h20, 8'h04);
    exp_q.push_back({1'b0, 8'h4B}); exp_q.push_back({1'b0, 8'hA1});
    exp_q.push_back({1'b0, 8'hB2}); exp_q.push_back({1'b1, 8'hC3});
    token(8'h69, 7'd0, 1'b0, 1'b1, "R8 data ep0");
    host_rd(6'h20, 8'h5A, "R8 field reset");
    push_hs(8'h5A); token(8'h69, 7'd0, 1'b0, 1'b1, "R8 repeat NAK");

    host_wr(6'h22, 8'h05);
    host_rd(6'h22, 8'h00, "R10 pending only");
    host_wr(6'h20, 8'h1E);
    push_hs(8'h1E); token(8'h69, 7'd0, 1'b0, 1'b1, "R8 stall hs");
    host_rd(6'h22, 8'h00, "R10 no commit on hs");
    host_rd(6'h20, 8'h1E, "R8 hs field kept");
    host_wr(6'h10, 8'hC3); host_wr(6'h11, 8'h01); host_wr(6'h12, 8'h02);
    host_wr(6'h21, 8'h03);
    exp_q.push_back({1'b0, 8'hC3}); exp_q.push_back({1'b0, 8'h01});
    exp_q.push_back({1'b1, 8'h02});
    token(8'h69, 7'd0, 1'b1, 1'b1, "R3 ep1 data");
    host_rd(6'h22, 8'h05, "R10 commit after data");
    host_rd(6'h21, 8'h5A, "R8 field1 reset");

    token(8'h2D, 7'd5, 1'b0, 1'b0, "R4 setup");
    token(8'h2D, 7'd3, 1'b0, 1'b0, "R3 wrong addr");
    pkt[0] = 8'hC3; pkt[1] = 8'h00; pkt[2] = 8'h00;
    send_pkt(3, 1'b0, "R3 token cleared");

    token(8'h2D, 7'd5, 1'b0, 1'b0, "R4 setup");
    pkt[0] = 8'hC3;
    for (int i = 0; i < 8; i++) pkt[i+1] = 8'h10 + 8'(i);
    pkt[9] = 8'hAA; pkt[10] = 8'hBB;
    push_hs(8'hD2); send_pkt(11, 1'b1, "R6 store");
    host_rd(6'h24, 8'd10, "R6 len");
    host_rd(6'h25, 8'h2D, "R6 token");
    host_rd(6'h00, 8'h10, "R6 byte0");
    host_rd(6'h09, 8'hBB, "R6 byte9");

    host_wr(6'h20, 8'h02);
    push_hs(8'h5A); token(8'h69, 7'd5, 1'b0, 1'b1, "R7 busy IN");
    host_rd(6'h20, 8'h02, "R7 field kept");

    token(8'hE1, 7'd5, 1'b0, 1'b0, "R4 out");
    pkt[0] = 8'h4B; pkt[1] = 8'h77; pkt[2] = 8'h66; pkt[3] = 8'h55; pkt[4] = 8'h44;
    push_hs(8'h5A); send_pkt(5, 1'b1, "R5 busy data");
    host_rd(6'h24, 8'd10, "R5 len kept");
    host_rd(6'h00, 8'h10, "R5 byte kept");

    host_wr(6'h23, 8'h00);
    host_rd(6'h24, 8'h00, "R13 release");
    pkt[0] = 8'h4B; pkt[1] = 8'h00; pkt[2] = 8'h00;
    push_hs(8'hD2); send_pkt(3, 1'b1, "R6 zero payload");
    host_rd(6'h24, 8'h00, "R6 not stored");

    pkt[0] = 8'hD2; pkt[1] = 8'h00;
    send_pkt(2, 1'b0, "R2 short");
    pkt[0] = 8'hC3; pkt[1] = 8'h55; pkt[2] = 8'h01; pkt[3] = 8'h02;
    push_hs(8'hD2); send_pkt(4, 1'b1, "R2 token kept");
    host_rd(6'h24, 8'd3, "R6 len3");
    host_rd(6'h25, 8'hE1, "R6 out token");
    host_rd(6'h00, 8'h55, "R6 byte0");

    host_wr(6'h23, 8'h00);
    pkt[0] = 8'hC3;
    for (int i = 1; i < RXD + 2; i++) pkt[i] = 8'(i);
    send_pkt(RXD + 2, 1'b0, "R12 oversize");
    host_rd(6'h24, 8'h00, "R12 not stored");

    stall = 1'b1;
    exp_q.push_back({1'b0, 8'h4B}); exp_q.push_back({1'b1, 8'hA1});
    token(8'h69, 7'd5, 1'b0, 1'b1, "R11 stalled data");
    stall = 1'b0;

    token(8'hE1, 7'd5, 1'b0, 1'b0, "R4 out");
    pkt[0] = 8'hA5; pkt[1] = 8'h05; pkt[2] = 8'h00;
    send_pkt(3, 1'b0, "R4 other pid");
    pkt[0] = 8'hC3; pkt[1] = 8'h99; pkt[2] = 8'h00; pkt[3] = 8'h00;
    send_pkt(4, 1'b0, "R4 cleared no reply");
    host_rd(6'h24, 8'h00, "R4 nothing stored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule